// File: doc/BRIEF.md
# Effective Address Generator

This block forms the memory address for every load and store of a 32-bit load-store processor core. The decoder hands it an addressing-mode code, an access size and the operand values it needs (the base register, R0, the global base, the jump-table base, the program counter and a raw displacement field). One cycle later the block presents the address and, for the modes that move a pointer, the new value to write back into the base register. Because register 15 serves as the stack pointer, pushes are pre-decrement accesses and pops are post-increment accesses.

One mode is double-indirect. It adds a scaled displacement to the jump-table base, reads a 32-bit word from that location over a simple request/response port, and uses the word read as the final address. While this read is outstanding the block reports busy and ignores new requests. It reports the address with a valid strobe only after the response arrives.

Top module: `ea_gen`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, valid_o, busy_o, mem_req_o and wb_en_o are 0.
- R2: Size codes are 0 byte, 1 word, 2 longword and 3, which acts as longword. The step and scale factor is 1, 2 or 4. Mode 1 (post-increment) gives addr_o = rn_i and wb_val_o = rn_i + step, with wb_en_o = 1.
- R3: Mode 2 (pre-decrement) gives addr_o = wb_val_o = rn_i - step, with wb_en_o = 1. All sums wrap modulo 2^32.
- R4: Mode 3 gives rn_i + zero-extended disp_i[3:0] times the scale. Mode 4 gives rn_i + zero-extended disp_i[11:0] times the scale.
- R5: Mode 0 gives rn_i. Mode 5 gives rn_i + r0_i. Mode 7 gives gbr_i + r0_i.
- R6: Mode 6 gives gbr_i + zero-extended disp_i[7:0] times the scale.
- R7: Mode 9 (PC-relative) gives pc_i + zero-extended disp_i[7:0] times the scale (2 for word, 4 for longword).
- R8: An accepted mode 8 request raises busy_o and mem_req_o on the next cycle, with mem_addr_o = tbr_i + disp_i[7:0] * 4. All three hold steady until a cycle in which mem_rvalid_i is 1.
- R9: In the cycle after mem_rvalid_i is sampled high while busy, busy_o and mem_req_o are 0, valid_o is 1, addr_o equals that mem_rdata_i, and wb_en_o is 0.
- R10: A request is accepted when start_i is 1 and busy_o is 0. For modes 0-7 and 9, valid_o is high for exactly the one cycle after acceptance. wb_en_o is 1 only for modes 1 and 2.
- R11: start_i is ignored while busy_o is 1. Mode codes 10-15 produce no valid_o, no busy_o and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Access size code |
| rn_i | input | 32 | Base register value |
| r0_i | input | 32 | Index register value |
| gbr_i | input | 32 | Global base register |
| tbr_i | input | 32 | Jump-table base register |
| pc_i | input | 32 | Program counter |
| disp_i | input | 12 | Raw displacement field |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table read address |
| busy_o | output | 1 | Table read outstanding |
| valid_o | output | 1 | Address valid strobe |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 32 | Base register write-back value |

## Verification
The assertions assume that mem_rvalid_i is raised only while busy_o is high and that the response data is stable in the cycle it is sampled. The bench raises the response strobe only after it has seen busy_o, for exactly one cycle, after a random wait. The bench also presents new requests while a table read is pending. It does this to show that they are dropped, never to overlap a response.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    EA_IND  = 4'd0,
    EA_POST = 4'd1,
    EA_PRE  = 4'd2,
    EA_DSH  = 4'd3,
    EA_DLG  = 4'd4,
    EA_IDX  = 4'd5,
    EA_GDSP = 4'd6,
    EA_GIDX = 4'd7,
    EA_TBL  = 4'd8,
    EA_PCR  = 4'd9
  } ea_mode_e;

  localparam logic [3:0] EA_LAST = 4'd9;

  // size code 3 behaves as longword
  function automatic logic [1:0] sz_shift(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction
endpackage

// File: rtl/ea_scale.sv
module ea_scale #(
  parameter int IW = 4,
  parameter int AW = 32
) (
  input  logic [IW-1:0] val_i,
  input  logic [1:0]    sh_i,
  output logic [AW-1:0] out_o
);
  logic [AW-1:0] ext;
  assign ext   = {{(AW-IW){1'b0}}, val_i};
  assign out_o = ext << sh_i;
endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int AW = 32
) (
  input  logic [3:0]    mode_i,
  input  logic [1:0]    sh_i,
  input  logic [AW-1:0] rn_i,
  input  logic [AW-1:0] r0_i,
  input  logic [AW-1:0] gbr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] d4s_i,
  input  logic [AW-1:0] d8s_i,
  input  logic [AW-1:0] d12s_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          legal_o,
  output logic          tbl_o
);
  import ea_pkg::*;
  logic [AW-1:0] step, inc, dec;
  assign step = {{(AW-1){1'b0}}, 1'b1} << sh_i;
  assign inc  = rn_i + step;
  assign dec  = rn_i - step;

  always_comb begin
    addr_o   = rn_i;
    wb_en_o  = 1'b0;
    wb_val_o = rn_i;
    legal_o  = (mode_i <= EA_LAST);
    tbl_o    = (mode_i == EA_TBL);
    case (mode_i)
      EA_POST: begin wb_en_o = 1'b1; wb_val_o = inc; end
      EA_PRE:  begin addr_o = dec; wb_en_o = 1'b1; wb_val_o = dec; end
      EA_DSH:  addr_o = rn_i + d4s_i;
      EA_DLG:  addr_o = rn_i + d12s_i;
      EA_IDX:  addr_o = rn_i + r0_i;
      EA_GDSP: addr_o = gbr_i + d8s_i;
      EA_GIDX: addr_o = gbr_i + r0_i;
      EA_PCR:  addr_o = pc_i + d8s_i;
      default: addr_o = rn_i;
    endcase
  end
endmodule

// File: rtl/ea_tbl_seq.sv
module ea_tbl_seq #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] slot_addr_i,
  input  logic          rvalid_i,
  output logic          busy_o,
  output logic [AW-1:0] req_addr_o,
  output logic          done_o
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      req_addr_o <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (go_i) begin
          st_q       <= S_WAIT;
          req_addr_o <= slot_addr_i;
        end
        S_WAIT: if (rvalid_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == S_WAIT);
  assign done_o = busy_o && rvalid_i;
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] rn_i,
  input  logic [AW-1:0] r0_i,
  input  logic [AW-1:0] gbr_i,
  input  logic [AW-1:0] tbr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  import ea_pkg::*;
  localparam int SW = 4;
  localparam int MW = 8;

  logic [1:0]    sh;
  logic [AW-1:0] d4s, d8s, d12s, d8t;
  logic [AW-1:0] c_addr, c_wb;
  logic          c_wb_en, c_legal, c_tbl;
  logic          accept, seq_busy, seq_done;

  assign sh     = sz_shift(size_i);
  assign accept = start_i && !seq_busy;

  ea_scale #(.IW(SW), .AW(AW)) u_s4  (.val_i(disp_i[SW-1:0]), .sh_i(sh),   .out_o(d4s));
  ea_scale #(.IW(MW), .AW(AW)) u_s8  (.val_i(disp_i[MW-1:0]), .sh_i(sh),   .out_o(d8s));
  ea_scale #(.IW(DW), .AW(AW)) u_s12 (.val_i(disp_i),         .sh_i(sh),   .out_o(d12s));
  ea_scale #(.IW(MW), .AW(AW)) u_st  (.val_i(disp_i[MW-1:0]), .sh_i(2'd2), .out_o(d8t));

  ea_calc #(.AW(AW)) u_calc (
    .mode_i(mode_i), .sh_i(sh), .rn_i(rn_i), .r0_i(r0_i), .gbr_i(gbr_i),
    .pc_i(pc_i), .d4s_i(d4s), .d8s_i(d8s), .d12s_i(d12s),
    .addr_o(c_addr), .wb_en_o(c_wb_en), .wb_val_o(c_wb),
    .legal_o(c_legal), .tbl_o(c_tbl)
  );

  ea_tbl_seq #(.AW(AW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(accept && c_tbl),
    .slot_addr_i(tbr_i + d8t), .rvalid_i(mem_rvalid_i),
    .busy_o(seq_busy), .req_addr_o(mem_addr_o), .done_o(seq_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      wb_en_o  <= 1'b0;
      wb_val_o <= '0;
    end else if (seq_done) begin
      valid_o  <= 1'b1;
      addr_o   <= mem_rdata_i;
      wb_en_o  <= 1'b0;
    end else if (accept && c_legal && !c_tbl) begin
      valid_o  <= 1'b1;
      addr_o   <= c_addr;
      wb_en_o  <= c_wb_en;
      wb_val_o <= c_wb;
    end else begin
      valid_o  <= 1'b0;
      wb_en_o  <= 1'b0;
    end
  end

  assign busy_o    = seq_busy;
  assign mem_req_o = seq_busy;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [1:0]    size_i,
  input logic [AW-1:0] rn_i,
  input logic          mem_rvalid_i,
  input logic [AW-1:0] mem_rdata_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          valid_o,
  input logic [AW-1:0] addr_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_val_o
);
  p_post_long_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mode_i == 4'd1 && size_i == 2'd2 |=>
      valid_o && wb_en_o && addr_o == $past(rn_i) && wb_val_o == $past(rn_i) + 32'd4);

  p_pre_long_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mode_i == 4'd2 && size_i == 2'd2 |=>
      valid_o && wb_en_o && addr_o == wb_val_o && wb_val_o == $past(rn_i) - 32'd4);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_rvalid_i |=> busy_o && mem_req_o && $stable(mem_addr_o));

  p_tbl_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mem_rvalid_i |=> valid_o && !busy_o && !wb_en_o && addr_o == $past(mem_rdata_i));

  p_wb_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o && !busy_o);

  p_busy_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  p_reserved_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mode_i > 4'd9 |=> !valid_o && !busy_o && !mem_req_o);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] rn_i = '0, r0_i = '0, gbr_i = '0, tbr_i = '0, pc_i = '0;
  logic [11:0] disp_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_req_o, busy_o, valid_o, wb_en_o;
  logic [31:0] mem_addr_o, addr_o, wb_val_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  ea_gen u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] scl(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [3:0] m, input logic [1:0] sz);
    logic [31:0] k;
    k = scl(sz);
    case (m)
      4'd1: return rn_i;
      4'd2: return rn_i - k;
      4'd3: return rn_i + 32'(disp_i[3:0]) * k;
      4'd4: return rn_i + 32'(disp_i) * k;
      4'd5: return rn_i + r0_i;
      4'd6: return gbr_i + 32'(disp_i[7:0]) * k;
      4'd7: return gbr_i + r0_i;
      4'd9: return pc_i + 32'(disp_i[7:0]) * k;
      default: return rn_i;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd0, 4'd5, 4'd7: return "R5";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd6: return "R6";
      4'd9: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic run_vec(input logic [3:0] m, input logic [1:0] sz, input int wait_n, input bit poke);
    logic [31:0] ea, slot, rd, held;
    @(negedge clk_i);
    mode_i = m; size_i = sz; start_i = 1'b1;
    ea   = exp_addr(m, sz);
    slot = tbr_i + 32'(disp_i[7:0]) * 32'd4;
    @(negedge clk_i);
    start_i = 1'b0;
    if (m == 4'd8) begin
      chk(busy_o && mem_req_o && !valid_o, "R8", {30'd0, busy_o, mem_req_o}, 32'd3);
      chk(mem_addr_o == slot, "R8", mem_addr_o, slot);
      held = mem_addr_o;
      for (int i = 0; i < wait_n; i++) begin
        if (poke && i == 0) begin
          mode_i = 4'd0; start_i = 1'b1; tbr_i = ~tbr_i;
          @(negedge clk_i);
          start_i = 1'b0;
          chk(!valid_o && busy_o, "R11", {31'd0, valid_o}, 32'd0);
        end else @(negedge clk_i);
        chk(busy_o && mem_addr_o == held, "R8", mem_addr_o, held);
      end
      rd = $urandom;
      mem_rvalid_i = 1'b1; mem_rdata_i = rd;
      @(negedge clk_i);
      mem_rvalid_i = 1'b0; mem_rdata_i = $urandom;
      chk(valid_o && !busy_o && !mem_req_o && !wb_en_o, "R9",
          {28'd0, valid_o, busy_o, mem_req_o, wb_en_o}, 32'h8);
      chk(addr_o == rd, "R9", addr_o, rd);
    end else if (m > 4'd9) begin
      chk(!valid_o && !busy_o && !mem_req_o, "R11", {30'd0, valid_o, busy_o}, 32'd0);
    end else begin
      chk(valid_o && !busy_o, "R10", {31'd0, valid_o}, 32'd1);
      chk(addr_o == ea, tag(m), addr_o, ea);
      chk(wb_en_o == (m == 4'd1 || m == 4'd2), "R10", {31'd0, wb_en_o}, 32'(m == 4'd1 || m == 4'd2));
      if (m == 4'd1) chk(wb_val_o == rn_i + scl(sz), "R2", wb_val_o, rn_i + scl(sz));
      if (m == 4'd2) chk(wb_val_o == rn_i - scl(sz), "R3", wb_val_o, rn_i - scl(sz));
    end
    @(negedge clk_i);
    chk(!valid_o && !wb_en_o, "R10", {31'd0, valid_o}, 32'd0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    #10;
    chk(!valid_o && !busy_o && !mem_req_o && !wb_en_o, "R1", {28'd0, valid_o, busy_o, mem_req_o, wb_en_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !busy_o && !mem_req_o && !wb_en_o, "R1", {28'd0, valid_o, busy_o, mem_req_o, wb_en_o}, 32'd0);

    // directed corners
    rn_i = 32'd0;
    run_vec(4'd2, 2'd2, 0, 1'b0);                       // R3 wrap below zero
    rn_i = 32'hFFFF_FFFF;
    run_vec(4'd1, 2'd0, 0, 1'b0);                       // R2 wrap above top
    rn_i = 32'h1000; disp_i = 12'hFFF;
    run_vec(4'd4, 2'd3, 0, 1'b0);                       // R4 max disp, size 3 as long
    run_vec(4'd3, 2'd1, 0, 1'b0);                       // R4 only low nibble used
    pc_i = 32'h8000_0000;
    run_vec(4'd9, 2'd1, 0, 1'b0);                       // R7 word
    run_vec(4'd9, 2'd2, 0, 1'b0);                       // R7 longword
    tbr_i = 32'hFFFF_FF00;
    run_vec(4'd8, 2'd0, 3, 1'b1);                       // R8 R11 start while busy
    run_vec(4'd15, 2'd2, 0, 1'b0);                      // R11 reserved

    for (int v = 0; v < 400; v++) begin
      rn_i = $urandom; r0_i = $urandom; gbr_i = $urandom;
      tbr_i = $urandom; pc_i = $urandom; disp_i = 12'($urandom);
      run_vec(4'($urandom), 2'($urandom), int'($urandom_range(0, 4)), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog act=%08h exp=%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule